// File: doc/BRIEF.md
# UART receive buffer with status view

This block sits between a UART's serial deserializer and the register file that software reads. Each byte the deserializer delivers, along with its line-error flags and any break indication, arrives here. The block keeps the bytes in one of two ways. With queueing enabled it holds them in a circular queue of parameterizable depth. With queueing disabled it holds only the most recent byte in a single holding register. It also produces the values behind the data, status and error registers, and sends one-cycle event strobes to the interrupt logic.

The register decoder turns host accesses into single-cycle strobes: a control write, a data read and an error-status read. The data byte and the error word are presented combinationally in the cycle of the read strobe. Any side effect of the read (a pop, a clear) takes place at the clock edge that ends that cycle. The control word has three bits: queue enable, receive-queue flush and transmit-queue flush. Both flush bits drop back to zero on their own one cycle after they are written.

Top module: `uart_rx_buffer`

## Requirements
- R1: After a synchronous active-low reset, the control readback, status word, error word, data-ready flag and both event strobes are all zero.
- R2: Control bit 0 enables queueing. Bit 1 (receive flush) and bit 2 (transmit flush) read back as 1 for exactly one cycle after a write, then clear themselves. Bit 2 is also presented on `tx_fifo_clear` for that cycle.
- R3: Status bits [7:0] hold the number of bytes queued and bit 8 is the full flag. When the queue holds DEPTH bytes, bit 8 is 1 and bits [7:0] read 0.
- R4: In queue mode, bytes are returned in arrival order. Each data read of a non-empty queue removes one byte. Afterwards `data_ready` is 1 only if bytes remain.
- R5: In queue mode, a data read of an empty queue returns 0 and pulses `err_event` in the following cycle.
- R6: A byte that arrives while the queue is full, with no read in the same cycle, is discarded. The occupancy stays unchanged and `err_event` pulses in the following cycle.
- R7: A byte arrival and a data read in the same cycle leave the occupancy unchanged at every level from 1 to DEPTH. Ordering is kept across pointer wrap-around.
- R8: The clock edge at which the receive-flush bit is applied empties the queue and clears `data_ready`. Any byte arriving in that cycle is discarded, and the enable bit is left as written.
- R9: With queueing disabled, each arriving byte overwrites the holding register and sets `data_ready`. A data read returns the held byte and clears `data_ready`, and it never raises `err_event`.
- R10: A break indication is stored as a zero byte, in both modes, and sets error bit 3.
- R11: Error bits are overrun (bit 0), parity (bit 1), framing (bit 2) and break (bit 3). Line-error flags that arrive with bytes accumulate. An error-status read returns the accumulated value and clears it at the end of that cycle.
- R12: `rx_event` pulses for one cycle after every byte that is actually stored, in either mode. It does not pulse for a discarded byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr_en | input | 1 | Control word write strobe |
| ctrl_wr_data | input | 3 | Control value: [0] enable, [1] receive flush, [2] transmit flush |
| ctrl_rd_data | output | 3 | Control word readback |
| tx_fifo_clear | output | 1 | Transmit-queue flush request, one cycle |
| rx_valid | input | 1 | Received byte strobe from the deserializer |
| rx_byte | input | 8 | Received byte |
| rx_line_err | input | 3 | Line errors with the byte: [0] overrun, [1] parity, [2] framing |
| rx_break | input | 1 | Break condition strobe |
| data_rd_en | input | 1 | Data register read strobe |
| data_rd_value | output | 8 | Byte returned by the data read |
| data_ready | output | 1 | Received data available |
| fifo_status | output | 9 | [7:0] occupancy, [8] full |
| err_rd_en | input | 1 | Error status read strobe |
| err_status | output | 4 | Accumulated error bits |
| rx_event | output | 1 | Byte-stored event strobe |
| err_event | output | 1 | Underflow or overflow event strobe |

## Verification
The queue is first filled one byte at a time from empty to full. The status word is checked at every level, which shows whether the count field and the full encoding agree. The queue is then drained, which shows the arrival order and the `data_ready` transition after the last pop.

Simultaneous arrival and read are then run at every occupancy from one to full, each for twice the depth. This checks the full-but-popping case and the pointer wrap against plain overflow. Reads past empty and arrivals past full isolate the two error paths. Separate runs in holding mode, with a break indication and with mixed line errors cover the overwrite, the zero byte and the accumulate-then-clear behaviour.

// File: rtl/uart_rxb_pkg.sv
// Package: uart_rxb_pkg
// Shared field positions and widths for the UART receive buffer.
// Assumes byte-wide data; the status count field is fixed at 8 bits,
// so DEPTH must not exceed 256.
package uart_rxb_pkg;

    localparam int DATA_W      = 8;

    // control word layout
    localparam int CTRL_W      = 3;
    localparam int CTRL_EN     = 0;
    localparam int CTRL_RXFL   = 1;
    localparam int CTRL_TXFL   = 2;

    // status word layout
    localparam int STAT_CNT_W  = 8;
    localparam int STAT_W      = STAT_CNT_W + 1;

    // error word layout
    localparam int LINE_ERR_W  = 3;
    localparam int ERR_W       = LINE_ERR_W + 1;
    localparam int ERR_BRK     = 3;

    typedef struct packed {
        logic brk;
        logic framing;
        logic parity;
        logic overrun;
    } rxb_err_t;

endpackage

// File: rtl/uart_rxb_ctrl.sv
// Module: uart_rxb_ctrl
// Holds the control word. The enable bit is retained; the two flush bits
// are held for exactly one cycle after being written and then drop to zero.
// Assumes writes arrive as single-cycle strobes.
module uart_rxb_ctrl
    import uart_rxb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] word,
    output logic              fifo_en,
    output logic              rx_flush,
    output logic              tx_flush
);

    logic [CTRL_W-1:0] ctrl_q;

    // control register: load on write, otherwise self-clear the flush bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wr_data;
        end else begin
            ctrl_q[CTRL_RXFL] <= 1'b0;
            ctrl_q[CTRL_TXFL] <= 1'b0;
        end
    end

    assign word     = ctrl_q;
    assign fifo_en  = ctrl_q[CTRL_EN];
    assign rx_flush = ctrl_q[CTRL_RXFL];
    assign tx_flush = ctrl_q[CTRL_TXFL];

endmodule

// File: rtl/uart_rxb_store.sv
// Module: uart_rxb_store
// Circular byte queue with store and retrieve pointers and an explicit
// occupancy counter. The caller guarantees that push is never asserted
// while full without pop, and pop never while empty. Clear has priority.
module uart_rxb_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       push,
    input  logic                       pop,
    input  logic [DATA_W-1:0]          push_data,
    output logic [DATA_W-1:0]          head_data,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       full,
    output logic                       empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [PTR_W-1:0]  wr_ptr_inc, rd_ptr_inc;
    logic [CNT_W-1:0]  cnt_q;

    // pointer advance: free wrap for power-of-two depths, compare otherwise
    generate
        if ((1 << PTR_W) == DEPTH) begin : g_pow2
            assign wr_ptr_inc = wr_ptr + 1'b1;
            assign rd_ptr_inc = rd_ptr + 1'b1;
        end else begin : g_modn
            assign wr_ptr_inc = (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            assign rd_ptr_inc = (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    // storage array write port
    always_ff @(posedge clk) begin
        if (push && !clear) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // store pointer
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
        end else if (push) begin
            wr_ptr <= wr_ptr_inc;
        end
    end

    // retrieve pointer
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rd_ptr <= '0;
        end else if (pop) begin
            rd_ptr <= rd_ptr_inc;
        end
    end

    // occupancy counter, unchanged on simultaneous push and pop
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else begin
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head_data = mem[rd_ptr];
    assign level     = cnt_q;
    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign empty     = (cnt_q == '0);

endmodule

// File: rtl/uart_rxb_errstat.sv
// Module: uart_rxb_errstat
// Sticky error word. New error bits are OR-ed in; a read strobe clears the
// bits present during the read, while bits arriving in the same cycle stay.
module uart_rxb_errstat
    import uart_rxb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  rxb_err_t         set_bits,
    input  logic             rd_en,
    output logic [ERR_W-1:0] word
);

    logic [ERR_W-1:0] err_q;

    // accumulate errors, clear on read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= (rd_en ? '0 : err_q) | set_bits;
        end
    end

    assign word = err_q;

endmodule

// File: rtl/uart_rx_buffer.sv
// Module: uart_rx_buffer
// Receive side of a UART register block: queues or holds received bytes,
// builds the status word, data-ready flag and error word, and strobes
// receive and error events. Assumes one deserializer byte per cycle at most
// and single-cycle read strobes from the register decoder.
module uart_rx_buffer
    import uart_rxb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctrl_wr_en,
    input  logic [CTRL_W-1:0]     ctrl_wr_data,
    output logic [CTRL_W-1:0]     ctrl_rd_data,
    output logic                  tx_fifo_clear,
    input  logic                  rx_valid,
    input  logic [DATA_W-1:0]     rx_byte,
    input  logic [LINE_ERR_W-1:0] rx_line_err,
    input  logic                  rx_break,
    input  logic                  data_rd_en,
    output logic [DATA_W-1:0]     data_rd_value,
    output logic                  data_ready,
    output logic [STAT_W-1:0]     fifo_status,
    input  logic                  err_rd_en,
    output logic [ERR_W-1:0]      err_status,
    output logic                  rx_event,
    output logic                  err_event
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              fifo_en, rx_flush;
    logic              in_valid;
    logic [DATA_W-1:0] in_byte;
    logic              q_push, q_pop, q_full, q_empty;
    logic [DATA_W-1:0] q_head;
    logic [CNT_W-1:0]  q_level, level_nxt;
    logic              room, dropped, underflow, hold_wr;
    logic [DATA_W-1:0] hold_q;
    logic              rdy_q, rx_ev_q, err_ev_q;
    rxb_err_t          err_set;

    uart_rxb_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctrl_wr_en),
        .wr_data  (ctrl_wr_data),
        .word     (ctrl_rd_data),
        .fifo_en  (fifo_en),
        .rx_flush (rx_flush),
        .tx_flush (tx_fifo_clear)
    );

    // incoming byte select: a break enters as a zero byte
    always_comb begin
        in_valid = rx_valid | rx_break;
        in_byte  = rx_break ? '0 : rx_byte;
    end

    // queue admission: pop frees a slot in the same cycle, flush wins
    always_comb begin
        q_pop     = fifo_en & data_rd_en & ~q_empty & ~rx_flush;
        underflow = fifo_en & data_rd_en & q_empty;
        room      = ~q_full | q_pop;
        q_push    = fifo_en & in_valid & room & ~rx_flush;
        dropped   = fifo_en & in_valid & ~room & ~rx_flush;
        hold_wr   = ~fifo_en & in_valid & ~rx_flush;
        level_nxt = q_level + CNT_W'(q_push) - CNT_W'(q_pop);
    end

    uart_rxb_store #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (rx_flush),
        .push      (q_push),
        .pop       (q_pop),
        .push_data (in_byte),
        .head_data (q_head),
        .level     (q_level),
        .full      (q_full),
        .empty     (q_empty)
    );

    // single holding register used while queueing is disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (hold_wr) begin
            hold_q <= in_byte;
        end
    end

    // data-ready flag for both modes
    always_ff @(posedge clk) begin
        if (!rst_n || rx_flush) begin
            rdy_q <= 1'b0;
        end else if (fifo_en) begin
            rdy_q <= (level_nxt != '0);
        end else if (hold_wr) begin
            rdy_q <= 1'b1;
        end else if (data_rd_en) begin
            rdy_q <= 1'b0;
        end
    end

    // event strobes toward the interrupt logic
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_ev_q  <= 1'b0;
            err_ev_q <= 1'b0;
        end else begin
            rx_ev_q  <= q_push | hold_wr;
            err_ev_q <= dropped | underflow;
        end
    end

    // error bits raised by this cycle's input
    always_comb begin
        err_set         = '0;
        err_set.overrun = rx_valid & rx_line_err[0];
        err_set.parity  = rx_valid & rx_line_err[1];
        err_set.framing = rx_valid & rx_line_err[2];
        err_set.brk     = rx_break;
    end

    uart_rxb_errstat u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (err_set),
        .rd_en    (err_rd_en),
        .word     (err_status)
    );

    // read data mux and status word assembly
    always_comb begin
        if (!fifo_en) begin
            data_rd_value = hold_q;
        end else if (q_empty) begin
            data_rd_value = '0;
        end else begin
            data_rd_value = q_head;
        end
        if (q_full) begin
            fifo_status = {1'b1, {STAT_CNT_W{1'b0}}};
        end else begin
            fifo_status = {1'b0, STAT_CNT_W'(q_level)};
        end
    end

    assign data_ready = rdy_q;
    assign rx_event   = rx_ev_q;
    assign err_event  = err_ev_q;

endmodule

// File: rtl/uart_rx_buffer_checker.sv
// Module: uart_rx_buffer_checker
// Port-level properties of uart_rx_buffer, attached through bind.
module uart_rx_buffer_checker
    import uart_rxb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ctrl_wr_en,
    input logic [CTRL_W-1:0]     ctrl_rd_data,
    input logic                  rx_valid,
    input logic                  rx_break,
    input logic                  data_rd_en,
    input logic [DATA_W-1:0]     data_rd_value,
    input logic                  data_ready,
    input logic [STAT_W-1:0]     fifo_status,
    input logic                  err_rd_en,
    input logic [ERR_W-1:0]      err_status,
    input logic                  rx_event,
    input logic                  err_event
);

    a_r2_flush_bits_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd_data[2:1] != 2'b00 && !ctrl_wr_en) |=> (ctrl_rd_data[2:1] == 2'b00));

    a_r3_full_hides_count: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_status[8] |-> (fifo_status[7:0] == 8'd0));

    a_r3_count_below_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_status[7:0] < 9'(DEPTH)));

    a_r4_ready_tracks_level: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_rd_data[0]) && ctrl_rd_data[0]) |-> (data_ready == (fifo_status != '0)));

    a_r5_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd_data[0] && !ctrl_rd_data[1] && data_rd_en && fifo_status == '0)
        |-> (data_rd_value == '0));

    a_r5_empty_read_event: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd_data[0] && data_rd_en && fifo_status == '0) |=> err_event);

    a_r6_overflow_event: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd_data[0] && !ctrl_rd_data[1] && !ctrl_wr_en && fifo_status[8]
         && (rx_valid || rx_break) && !data_rd_en) |=> (err_event && fifo_status[8]));

    a_r7_pushpop_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd_data[0] && !ctrl_rd_data[1] && !ctrl_wr_en && fifo_status != '0
         && (rx_valid || rx_break) && data_rd_en) |=> $stable(fifo_status));

    a_r11_read_clears_errors: assert property (@(posedge clk) disable iff (!rst_n)
        (err_rd_en && !rx_valid && !rx_break) |=> (err_status == '0));

    a_r12_event_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |-> $past(rx_valid || rx_break));

endmodule

bind uart_rx_buffer uart_rx_buffer_checker #(.DEPTH(DEPTH)) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_wr_en    (ctrl_wr_en),
    .ctrl_rd_data  (ctrl_rd_data),
    .rx_valid      (rx_valid),
    .rx_break      (rx_break),
    .data_rd_en    (data_rd_en),
    .data_rd_value (data_rd_value),
    .data_ready    (data_ready),
    .fifo_status   (fifo_status),
    .err_rd_en     (err_rd_en),
    .err_status    (err_status),
    .rx_event      (rx_event),
    .err_event     (err_event)
);

// File: tb/uart_rx_buffer_test.sv
// Bench for uart_rx_buffer on a small depth: sweeps every occupancy level
// and checks against a queue model held in the bench.
module uart_rx_buffer_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr_en = 1'b0;
    logic [2:0] ctrl_wr_data = '0;
    logic [2:0] ctrl_rd_data;
    logic       tx_fifo_clear;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [2:0] rx_line_err = '0;
    logic       rx_break = 1'b0;
    logic       data_rd_en = 1'b0;
    logic [7:0] data_rd_value;
    logic       data_ready;
    logic [8:0] fifo_status;
    logic       err_rd_en = 1'b0;
    logic [3:0] err_status;
    logic       rx_event;
    logic       err_event;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] model[$];

    uart_rx_buffer #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data),
        .ctrl_rd_data(ctrl_rd_data), .tx_fifo_clear(tx_fifo_clear),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_line_err(rx_line_err),
        .rx_break(rx_break), .data_rd_en(data_rd_en),
        .data_rd_value(data_rd_value), .data_ready(data_ready),
        .fifo_status(fifo_status), .err_rd_en(err_rd_en),
        .err_status(err_status), .rx_event(rx_event), .err_event(err_event)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // watchdog: a hung run counts as one failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int stat_of(input int n);
        return (n == DEPTH) ? 32'h100 : n;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_ctrl(input logic [2:0] v);
        ctrl_wr_en = 1'b1; ctrl_wr_data = v;
        tick();
        ctrl_wr_en = 1'b0;
    endtask

    // flush the queue: write, then let the flush edge pass
    task automatic flush_fifo(input logic [2:0] keep_en);
        write_ctrl(keep_en | 3'b010);
        tick();
        model.delete();
    endtask

    task automatic push_byte(input logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b;
        tick();
        rx_valid = 1'b0;
    endtask

    task automatic read_data(output logic [7:0] v);
        data_rd_en = 1'b1;
        #1 v = data_rd_value;
        tick();
        data_rd_en = 1'b0;
    endtask

    initial begin
        logic [7:0] got;
        logic [7:0] exp_b;
        @(negedge clk);
        tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        check(ctrl_rd_data == 0, "R1 ctrl", ctrl_rd_data, 0);
        check(fifo_status == 0, "R1 status", fifo_status, 0);
        check(err_status == 0 && !data_ready, "R1 err/ready", {err_status, data_ready}, 0);
        check(!rx_event && !err_event, "R1 events", {rx_event, err_event}, 0);

        // R2: flush bits hold one cycle then self-clear
        write_ctrl(3'b111);
        check(ctrl_rd_data == 3'b111, "R2 written", ctrl_rd_data, 7);
        check(tx_fifo_clear == 1'b1, "R2 tx clear pulse", tx_fifo_clear, 1);
        tick();
        check(ctrl_rd_data == 3'b001, "R2 self clear", ctrl_rd_data, 1);
        check(tx_fifo_clear == 1'b0, "R2 tx clear drop", tx_fifo_clear, 0);

        // R3 / R12: fill sweep from empty to full
        for (int n = 1; n <= DEPTH; n++) begin
            exp_b = 8'(8'h30 + n * 7);
            push_byte(exp_b);
            model.push_back(exp_b);
            check(rx_event, "R12 stored event", rx_event, 1);
            check(int'(fifo_status) == stat_of(n), "R3 level", fifo_status, stat_of(n));
            check(data_ready, "R4 ready while filling", data_ready, 1);
        end

        // R6: arrival when full is dropped
        push_byte(8'hEE);
        check(err_event, "R6 overflow event", err_event, 1);
        check(!rx_event, "R12 no event on drop", rx_event, 0);
        check(int'(fifo_status) == stat_of(DEPTH), "R6 level kept", fifo_status, stat_of(DEPTH));

        // R4: drain in order
        for (int n = DEPTH; n >= 1; n--) begin
            exp_b = model.pop_front();
            read_data(got);
            check(got == exp_b, "R4 order", got, exp_b);
            check(int'(fifo_status) == stat_of(n - 1), "R3 drain level", fifo_status, stat_of(n - 1));
            check(data_ready == (n > 1), "R4 ready after pop", data_ready, (n > 1));
        end

        // R5: read from empty
        read_data(got);
        check(got == 0, "R5 empty value", got, 0);
        check(err_event, "R5 underflow event", err_event, 1);
        check(fifo_status == 0, "R5 still empty", fifo_status, 0);

        // R7: simultaneous push and pop at every level, wrapping pointers
        for (int lvl = 1; lvl <= DEPTH; lvl++) begin
            flush_fifo(3'b001);
            for (int k = 0; k < lvl; k++) begin
                exp_b = 8'(lvl * 40 + k);
                push_byte(exp_b);
                model.push_back(exp_b);
            end
            for (int k = 0; k < 2 * DEPTH; k++) begin
                exp_b = 8'(lvl * 17 + k * 5 + 3);
                rx_valid = 1'b1; rx_byte = exp_b; data_rd_en = 1'b1;
                #1 got = data_rd_value;
                check(got == model[0], "R7 head order", got, model[0]);
                tick();
                rx_valid = 1'b0; data_rd_en = 1'b0;
                void'(model.pop_front());
                model.push_back(exp_b);
                check(int'(fifo_status) == stat_of(lvl), "R7 level kept", fifo_status, stat_of(lvl));
                check(rx_event && !err_event, "R7 events", {rx_event, err_event}, 2);
            end
        end

        // R8: flush edge empties queue and discards that cycle's byte
        write_ctrl(3'b011);
        rx_valid = 1'b1; rx_byte = 8'hA5;
        tick();
        rx_valid = 1'b0;
        check(fifo_status == 0, "R8 emptied", fifo_status, 0);
        check(!data_ready, "R8 ready cleared", data_ready, 0);
        check(ctrl_rd_data == 3'b001, "R8 enable kept", ctrl_rd_data, 1);
        check(!rx_event, "R8 byte discarded", rx_event, 0);
        model.delete();

        // R10: break in queue mode stores zero and sets bit 3
        rx_break = 1'b1;
        tick();
        rx_break = 1'b0;
        check(fifo_status == 1, "R10 break stored", fifo_status, 1);
        check(err_status == 4'b1000, "R10 break bit", err_status, 8);
        read_data(got);
        check(got == 0, "R10 zero byte", got, 0);

        // R11: line errors accumulate, read returns then clears
        err_rd_en = 1'b1; tick(); err_rd_en = 1'b0;
        rx_line_err = 3'b001; push_byte(8'h11);
        rx_line_err = 3'b100; push_byte(8'h22);
        rx_line_err = 3'b000;
        check(err_status == 4'b0101, "R11 accumulate", err_status, 5);
        err_rd_en = 1'b1;
        #1 check(err_status == 4'b0101, "R11 read value", err_status, 5);
        tick();
        err_rd_en = 1'b0;
        check(err_status == 0, "R11 cleared", err_status, 0);
        rx_line_err = 3'b010; push_byte(8'h33); rx_line_err = 3'b000;
        check(err_status == 4'b0010, "R11 parity bit", err_status, 2);
        err_rd_en = 1'b1; tick(); err_rd_en = 1'b0;

        // R9: holding mode overwrites and read clears ready
        flush_fifo(3'b000);
        push_byte(8'h5A);
        check(rx_event, "R12 holding event", rx_event, 1);
        push_byte(8'hC3);
        check(data_ready, "R9 ready set", data_ready, 1);
        read_data(got);
        check(got == 8'hC3, "R9 newest byte", got, 8'hC3);
        check(!data_ready, "R9 ready cleared", data_ready, 0);
        read_data(got);
        check(got == 8'hC3 && !err_event, "R9 reread no error", {got, err_event}, 16'h0186);

        // R10: break in holding mode
        rx_break = 1'b1; tick(); rx_break = 1'b0;
        read_data(got);
        check(got == 0, "R10 holding zero", got, 0);
        check(err_status[3], "R10 holding break bit", err_status, 8);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule